// File: doc/BRIEF.md
# FIFO Retransmit Read Controller

This block is the read-side control of a FIFO whose read data passes through an output register and which can replay its contents. The stored words can be read more than once. Holding `rt_n` low at a rising clock edge starts a retransmit. The read pointer returns to memory location zero, and reading then resumes from the oldest word written since master reset. The controller sits between an asynchronously read memory array, which it addresses through `mem_addr` and which returns `mem_data`, and the consumer of `dout`. It takes the write pointer from the write side and derives the fill count and the empty flag from it.

The level on `lat_mode_i` during master reset chooses how a retransmit behaves. A low level selects zero latency: location zero is loaded into the output register on the same edge that samples `rt_n` low, and the pointer moves on to location one. A high level selects normal latency: the retransmit edge only rewinds the pointer, and location zero reaches `dout` on the next read-enabled edge. In both modes the read enable is ignored on a retransmit edge. Master reset is synchronous and active low.

A replay returns the correct data only while no more than 2^AW words have been written since master reset, so that location zero still holds the first word.

Top module: `fifo_rtx_read`

## Requirements
- R1: While `mrst_n` is low at a rising edge, the read pointer and `dout` are cleared to zero, so `mem_addr` is 0 and `rd_count` equals `wr_ptr`.
- R2: The retransmit mode is taken from `lat_mode_i` (0 = zero latency, 1 = normal latency) at each edge with `mrst_n` low. Changes of `lat_mode_i` after reset have no effect.
- R3: An edge with `rt_n` high, `rd_en` high and the FIFO not empty loads `dout` with the word at the read pointer and advances the pointer by one.
- R4: An edge with `rd_en` high while the FIFO is empty leaves `dout`, `rd_count` and `empty` unchanged.
- R5: An edge with `rt_n` low sets the read pointer to location zero. The next location to be read is zero in normal mode and one in zero-latency mode.
- R6: In zero-latency mode, if at least one word has been written, the retransmit edge loads `dout` with the word at location zero and leaves `rd_count` equal to `wr_ptr` minus one.
- R7: In normal-latency mode, `dout` holds its value on the retransmit edge. The next edge with `rd_en` high loads the word at location zero.
- R8: `rd_en` has no effect on an edge that samples `rt_n` low.
- R9: Each retransmit replays the same word sequence from location zero, any number of times.
- R10: In zero-latency mode with `wr_ptr` equal to 0, a retransmit leaves `dout` unchanged and `rd_count` at 0.
- R11: `rd_count` is (`wr_ptr` minus read pointer) modulo 2^(AW+1), and `empty` is high exactly when `rd_count` is 0. Both are recomputed after a retransmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| mrst_n | input | 1 | Synchronous master reset, active low |
| lat_mode_i | input | 1 | Retransmit mode, sampled during reset: 0 zero latency, 1 normal |
| rt_n | input | 1 | Retransmit request, active low |
| rd_en | input | 1 | Read enable, active high |
| wr_ptr | input | AW+1 | Write pointer from the write side (words written since reset) |
| mem_addr | output | AW | Read address to the memory array |
| mem_data | input | DW | Word stored at `mem_addr` (asynchronous read) |
| dout | output | DW | Output register |
| empty | output | 1 | High when no unread word remains |
| rd_count | output | AW+1 | Number of unread words |

## Verification
The main test runs a normal-latency sequence and compares `dout`, `rd_count` and `empty` after every edge. The sequence includes:
- plain reads, which check that the pointer advances one location per read;
- reads on an empty FIFO, which must leave all outputs unchanged;
- a retransmit with `rd_en` held high, which separates a pointer rewind from a read wrongly taken on the same edge, because the count comes out as `wr_ptr` rather than `wr_ptr` minus one;
- a second retransmit followed by reads to empty, which shows that the replayed order is the same each time.

Directed zero-latency tests then check four cases:
- the word at location zero appears on the retransmit edge itself, which distinguishes the two modes;
- a retransmit on an FIFO that has never been written loads nothing;
- after `lat_mode_i` is toggled outside reset, the mode latched at reset still decides the behaviour;
- outputs and `mem_addr` during reset.

// File: rtl/fifo_rtx_pkg.sv
package fifo_rtx_pkg;

  // Retransmit latency selection, captured during master reset
  typedef enum logic {
    RTX_ZERO_LAT = 1'b0,
    RTX_NORM_LAT = 1'b1
  } rtx_mode_e;

endpackage

// File: rtl/rtx_mode_latch.sv
module rtx_mode_latch
  import fifo_rtx_pkg::*;
(
  input  logic      clk,
  input  logic      mrst_n,
  input  logic      mode_pin,
  output rtx_mode_e mode_q
);

  // The mode follows the pin only while reset is held
  always_ff @(posedge clk) begin
    if (!mrst_n) mode_q <= rtx_mode_e'(mode_pin);
  end

endmodule

// File: rtl/rtx_read_ptr.sv
module rtx_read_ptr #(
  parameter int AW = 4,
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          rewind,
  input  logic          skip_first,
  input  logic          advance,
  output logic [PW-1:0] rd_ptr
);

  localparam logic [PW-1:0] PTR_ONE = PW'(1);

  always_ff @(posedge clk) begin
    if (!mrst_n) begin
      rd_ptr <= '0;
    end else if (rewind) begin
      // Location zero already consumed when the replay loads it at once
      rd_ptr <= skip_first ? PTR_ONE : '0;
    end else if (advance) begin
      rd_ptr <= rd_ptr + PTR_ONE;
    end
  end

endmodule

// File: rtl/rtx_out_reg.sv
module rtx_out_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);

  always_ff @(posedge clk) begin
    if (!mrst_n)   dout <= '0;
    else if (load) dout <= din;
  end

endmodule

// File: rtl/fifo_rtx_read.sv
module fifo_rtx_read
  import fifo_rtx_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  logic          lat_mode_i,
  input  logic          rt_n,
  input  logic          rd_en,
  input  logic [AW:0]   wr_ptr,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_data,
  output logic [DW-1:0] dout,
  output logic          empty,
  output logic [AW:0]   rd_count
);

  localparam int PW = AW + 1;

  // Arithmetic kept in functions so the bench can restate it independently
  function automatic logic [PW-1:0] fill_count(logic [PW-1:0] w, logic [PW-1:0] r);
    return w - r;
  endfunction

  function automatic logic no_words(logic [PW-1:0] cnt);
    return cnt == '0;
  endfunction

  rtx_mode_e     mode_q;
  logic [PW-1:0] rd_ptr;

  // Named internal events
  logic rt_evt;      // retransmit sampled on this edge
  logic any_written; // location zero holds data
  logic zl_load;     // zero-latency replay loads location zero now
  logic rd_evt;      // ordinary read accepted on this edge
  logic out_load;

  rtx_mode_latch u_mode (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .mode_pin (lat_mode_i),
    .mode_q   (mode_q)
  );

  assign rd_count    = fill_count(wr_ptr, rd_ptr);
  assign empty       = no_words(rd_count);
  assign rt_evt      = !rt_n;
  assign any_written = wr_ptr != '0;
  assign zl_load     = rt_evt && (mode_q == RTX_ZERO_LAT) && any_written;
  assign rd_evt      = !rt_evt && rd_en && !empty;
  assign out_load    = zl_load || rd_evt;

  // A retransmit edge addresses location zero for the zero-latency load
  assign mem_addr = rt_evt ? '0 : rd_ptr[AW-1:0];

  rtx_read_ptr #(.AW(AW)) u_ptr (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .rewind     (rt_evt),
    .skip_first (zl_load),
    .advance    (rd_evt),
    .rd_ptr     (rd_ptr)
  );

  rtx_out_reg #(.DW(DW)) u_out (
    .clk    (clk),
    .mrst_n (mrst_n),
    .load   (out_load),
    .din    (mem_data),
    .dout   (dout)
  );

endmodule

// File: rtl/fifo_rtx_read_chk.sv
module fifo_rtx_read_chk
  import fifo_rtx_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          mrst_n,
  input logic          rt_n,
  input logic          rd_en,
  input logic          empty,
  input logic [AW:0]   wr_ptr,
  input logic [DW-1:0] mem_data,
  input logic [DW-1:0] dout,
  input logic [AW:0]   rd_ptr,
  input rtx_mode_e     mode_q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !mrst_n |=> (rd_ptr == '0 && dout == '0));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(mode_q));

  // R3
  read_adv_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (rt_n && rd_en && !empty) |=>
      (dout == $past(mem_data) && rd_ptr == $past(rd_ptr) + 1'b1));

  // R4
  empty_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (rt_n && empty) |=> ($stable(dout) && $stable(rd_ptr)));

  // R5
  norm_rewind_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!rt_n && mode_q == RTX_NORM_LAT) |=> rd_ptr == '0);

  // R6
  zl_load_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!rt_n && mode_q == RTX_ZERO_LAT && wr_ptr != '0) |=>
      (dout == $past(mem_data) && rd_ptr == 1));

  // R7
  norm_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!rt_n && mode_q == RTX_NORM_LAT) |=> $stable(dout));

  // R10
  zl_empty_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (!rt_n && wr_ptr == '0) |=> ($stable(dout) && rd_ptr == '0));

endmodule

bind fifo_rtx_read fifo_rtx_read_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .mrst_n   (mrst_n),
  .rt_n     (rt_n),
  .rd_en    (rd_en),
  .empty    (empty),
  .wr_ptr   (wr_ptr),
  .mem_data (mem_data),
  .dout     (dout),
  .rd_ptr   (rd_ptr),
  .mode_q   (mode_q)
);

// File: tb/fifo_rtx_read_test.sv
module fifo_rtx_read_test;

  localparam int  DW = 16;
  localparam int  AW = 4;
  localparam time CLK_PERIOD = 10;
  localparam int  NV = 17;

  typedef struct packed {
    logic        rt_n;
    logic        rd_en;
    logic [4:0]  wr;
    logic [15:0] dout;
    logic [4:0]  cnt;
  } vec_t;

  // Normal-latency walk; memory location i holds 16'hC000 + i
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 5'd0, 16'h0000, 5'd0},  // R4 read on empty
    '{1'b1, 1'b0, 5'd3, 16'h0000, 5'd3},  // R11 writes appear
    '{1'b1, 1'b1, 5'd3, 16'hC000, 5'd2},  // R3
    '{1'b1, 1'b1, 5'd3, 16'hC001, 5'd1},  // R3
    '{1'b1, 1'b1, 5'd5, 16'hC002, 5'd2},  // R3
    '{1'b0, 1'b1, 5'd5, 16'hC002, 5'd5},  // R5 R7 R8
    '{1'b1, 1'b1, 5'd5, 16'hC000, 5'd4},  // R7
    '{1'b1, 1'b1, 5'd5, 16'hC001, 5'd3},  // R9
    '{1'b1, 1'b0, 5'd5, 16'hC001, 5'd3},
    '{1'b0, 1'b0, 5'd6, 16'hC001, 5'd6},  // R5 second replay
    '{1'b1, 1'b1, 5'd6, 16'hC000, 5'd5},  // R9
    '{1'b1, 1'b1, 5'd6, 16'hC001, 5'd4},
    '{1'b1, 1'b1, 5'd6, 16'hC002, 5'd3},
    '{1'b1, 1'b1, 5'd6, 16'hC003, 5'd2},
    '{1'b1, 1'b1, 5'd6, 16'hC004, 5'd1},
    '{1'b1, 1'b1, 5'd6, 16'hC005, 5'd0},  // R11 empty
    '{1'b1, 1'b1, 5'd6, 16'hC005, 5'd0}   // R4
  };

  logic          clk = 1'b0;
  logic          mrst_n, lat_mode_i, rt_n, rd_en;
  logic [AW:0]   wr_ptr;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data, dout;
  logic          empty;
  logic [AW:0]   rd_count;
  logic [DW-1:0] mem [2**AW];

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_data = mem[mem_addr];

  fifo_rtx_read #(.DW(DW), .AW(AW)) uut (
    .clk        (clk),
    .mrst_n     (mrst_n),
    .lat_mode_i (lat_mode_i),
    .rt_n       (rt_n),
    .rd_en      (rd_en),
    .wr_ptr     (wr_ptr),
    .mem_addr   (mem_addr),
    .mem_data   (mem_data),
    .dout       (dout),
    .empty      (empty),
    .rd_count   (rd_count)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 time unit after the rising edge
  task automatic cyc(logic rt, logic re, logic [AW:0] wr);
    @(negedge clk);
    rt_n = rt; rd_en = re; wr_ptr = wr;
    @(posedge clk);
    #1;
  endtask

  task automatic check_out(string req, logic [DW-1:0] ed, logic [AW:0] ec);
    check({req, " dout"}, 32'(dout), 32'(ed));
    check({req, " count"}, 32'(rd_count), 32'(ec));
    check({req, " empty"}, 32'(empty), 32'(ec == 0));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = 16'hC000 + 16'(i);
    mrst_n = 1'b0; lat_mode_i = 1'b1; rt_n = 1'b1; rd_en = 1'b0; wr_ptr = '0;

    // R1 reset state, with a nonzero write pointer
    cyc(1'b1, 1'b1, 5'd2);
    cyc(1'b1, 1'b1, 5'd2);
    check("R1 dout", 32'(dout), 32'h0);
    check("R1 count", 32'(rd_count), 32'd2);
    check("R1 addr", 32'(mem_addr), 32'd0);
    check("R1 empty", 32'(empty), 32'd0);

    @(negedge clk); mrst_n = 1'b1; rd_en = 1'b0; wr_ptr = '0;

    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v].rt_n, VEC[v].rd_en, VEC[v].wr);
      check_out($sformatf("vec%0d R3/R4/R5/R7/R8/R9/R11", v), VEC[v].dout, VEC[v].cnt);
    end

    // Zero-latency mode
    @(negedge clk); mrst_n = 1'b0; lat_mode_i = 1'b0; wr_ptr = '0; rt_n = 1'b1;
    @(posedge clk); #1;
    check_out("R1 zl reset", 16'h0000, 5'd0);
    @(negedge clk); mrst_n = 1'b1;

    cyc(1'b0, 1'b0, 5'd0);
    check_out("R10 replay with nothing written", 16'h0000, 5'd0);
    cyc(1'b1, 1'b1, 5'd4);
    check_out("R3 zl read", 16'hC000, 5'd3);
    cyc(1'b1, 1'b1, 5'd4);
    check_out("R3 zl read", 16'hC001, 5'd2);
    cyc(1'b0, 1'b1, 5'd4);
    check_out("R6 R8 zl same-edge load", 16'hC000, 5'd3);
    cyc(1'b1, 1'b1, 5'd4);
    check_out("R9 zl continue", 16'hC001, 5'd2);

    @(negedge clk); lat_mode_i = 1'b1;
    cyc(1'b0, 1'b0, 5'd4);
    check_out("R2 mode pin ignored after reset", 16'hC000, 5'd3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule